// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit collects the event pulses of a serial master core into a single interrupt line for the host processor. Seven single-cycle event pulses arrive from the core, and each one sets its own bit in a pending register. The bit stays set until software clears it. Software clears pending bits by writing ones to them, so writing back a value it has just read clears exactly the bits that were seen.

The interrupt output is masked twice. A per-source mask register picks which pending bits can raise the line. A master-enable bit, the top bit of a separate register, can force the line low whatever is pending. The unit has the same 32-bit word register port as the controller it serves. Register writes and events take effect at the clock edge. Reads are combinational. A software reset word returns all three registers to zero.

Top module: `spi_irq_agg`

## Requirements
- R1: After the hardware reset, the pending register (offset 0x20), the mask register (offset 0x28) and the master-enable register (offset 0x1C) all read 0, and `irq` is low.
- R2: An event pulse on `evt[i]` sets pending bit i at the next clock edge, whether or not that source is masked. Bit meanings: 0 mode fault, 1 slave-mode fault, 2 TX FIFO empty, 3 TX underrun, 4 RX FIFO full, 5 RX overrun, 6 TX FIFO half empty.
- R3: A write to offset 0x20 clears every pending bit that has a 1 in the write data. Pending bits with a 0 in the write data are left unchanged.
- R4: If an event on bit i arrives in the same cycle as a write that clears bit i, the bit stays set.
- R5: The mask register stores write-data bits 6:0. Its bits 31:7 always read 0.
- R6: The master-enable register stores only write-data bit 31. Its bits 30:0 always read 0.
- R7: `irq` is high exactly when the master-enable bit is 1 and at least one pending bit has its mask bit set.
- R8: A write to offset 0x40 whose data has low nibble 0xA clears the pending, mask and master-enable registers. A clear on this write wins over an event in the same cycle. A write to 0x40 with any other value has no effect.
- R9: Writing to the pending register never sets a bit. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 7 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt | input | 7 | Event pulses from the core, one cycle each |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets these corner cases:
- An event that lands in the same cycle as its own clear. A design that lets the clear win would lose that event silently.
- A partial clear. A design that clears the whole register, or one that treats the write as a store, would clear or set the wrong bits.
- The two masking stages. The bench checks that a masked source is latched but does not raise `irq`, and that dropping the master-enable bit drops the line even while unmasked bits are pending.
- A software reset with the wrong key, and a correct key together with an event. Decoding the key loosely would wipe state by accident. Letting the event win would leave a stale bit pending after reset.

// File: rtl/spi_irq_agg.sv
module spi_irq_agg #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 7,
  parameter logic [ADDR_W-1:0] OFS_GEN  = 7'h1C,
  parameter logic [ADDR_W-1:0] OFS_PEND = 7'h20,
  parameter logic [ADDR_W-1:0] OFS_MASK = 7'h28,
  parameter logic [ADDR_W-1:0] OFS_SRST = 7'h40,
  parameter logic [3:0]        SRST_KEY = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] evt,
  output logic              irq
);
  localparam int PAD = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pend_q, mask_q;
  logic               gen_q;

  logic wr_pend, wr_mask, wr_gen, srst;
  assign wr_pend = reg_we && (reg_addr == OFS_PEND);
  assign wr_mask = reg_we && (reg_addr == OFS_MASK);
  assign wr_gen  = reg_we && (reg_addr == OFS_GEN);
  assign srst    = reg_we && (reg_addr == OFS_SRST) && (reg_wdata[3:0] == SRST_KEY);

  logic [NUM_SRC-1:0] clr;
  assign clr = wr_pend ? reg_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      pend_q <= '0;
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | evt;
      if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
      if (wr_gen)  gen_q  <= reg_wdata[DATA_W-1];
    end
  end

  assign irq = gen_q & |(pend_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_PEND)      reg_rdata = {{PAD{1'b0}}, pend_q};
    else if (reg_addr == OFS_MASK) reg_rdata = {{PAD{1'b0}}, mask_q};
    else if (reg_addr == OFS_GEN)  reg_rdata = {gen_q, {(DATA_W-1){1'b0}}};
  end

  assert_gen_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !irq);

  assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pend_q == '0 && mask_q == '0 && !gen_q && !irq));

  assert_gen_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_GEN) |-> (reg_rdata[DATA_W-2:0] == '0));

  assert_mask_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_MASK) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !srst) |=> pend_q[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && reg_wdata[i] && !evt[i]) |=> !pend_q[i]);
    assert_set_only_by_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(evt[i]));
  end
endmodule

// File: tb/spi_irq_agg_tb.sv
module spi_irq_agg_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [6:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt = 0;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic [6:0]  ev;
    logic [6:0]  chk;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 7'h00, 32'h0,        7'h05, 7'h20, 32'h05,       1'b0, 4'd2}, // R2 latch while masked
    '{1'b1, 7'h28, 32'hFFFFFFFF, 7'h00, 7'h28, 32'h7F,       1'b0, 4'd5}, // R5 mask width
    '{1'b1, 7'h1C, 32'hFFFFFFFF, 7'h00, 7'h1C, 32'h80000000, 1'b1, 4'd6}, // R6 top bit only
    '{1'b1, 7'h20, 32'h01,       7'h00, 7'h20, 32'h04,       1'b1, 4'd3}, // R3 partial clear
    '{1'b1, 7'h20, 32'h04,       7'h04, 7'h20, 32'h04,       1'b1, 4'd4}, // R4 event beats clear
    '{1'b1, 7'h20, 32'h04,       7'h00, 7'h20, 32'h00,       1'b0, 4'd7}, // R7 nothing pending
    '{1'b1, 7'h20, 32'h7F,       7'h00, 7'h20, 32'h00,       1'b0, 4'd9}, // R9 write never sets
    '{1'b1, 7'h28, 32'h10,       7'h20, 7'h20, 32'h20,       1'b0, 4'd7}, // R7 masked source
    '{1'b0, 7'h00, 32'h0,        7'h10, 7'h20, 32'h30,       1'b1, 4'd7}, // R7 unmasked source
    '{1'b1, 7'h1C, 32'h7FFFFFFF, 7'h00, 7'h1C, 32'h0,        1'b0, 4'd6}, // R6 master off
    '{1'b1, 7'h40, 32'h05,       7'h00, 7'h20, 32'h30,       1'b0, 4'd8}, // R8 wrong key
    '{1'b1, 7'h1C, 32'h80000000, 7'h00, 7'h28, 32'h10,       1'b1, 4'd8}, // R8 mask kept
    '{1'b1, 7'h40, 32'h0A,       7'h00, 7'h20, 32'h0,        1'b0, 4'd8}, // R8 soft reset
    '{1'b0, 7'h00, 32'h0,        7'h00, 7'h28, 32'h0,        1'b0, 4'd8}, // R8 mask cleared
    '{1'b0, 7'h00, 32'h0,        7'h00, 7'h1C, 32'h0,        1'b0, 4'd8}, // R8 master cleared
    '{1'b0, 7'h00, 32'h0,        7'h00, 7'h24, 32'h0,        1'b0, 4'd9}  // R9 unmapped read
  };

  task automatic check(input logic [6:0] a, input logic [31:0] exp_rd,
                       input logic exp_i, input int r);
    reg_addr = a;
    #1;
    n_run++;
    if (reg_rdata !== exp_rd || irq !== exp_i) begin
      n_fail++;
      $display("FAIL R%0d addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
               r, a, reg_rdata, irq, exp_rd, exp_i);
    end
  endtask

  task automatic step(input logic we, input logic [6:0] a, input logic [31:0] d,
                      input logic [6:0] e);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt = e;
    @(negedge clk);
    reg_we = 0; evt = 0; reg_wdata = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(7'h20, 32'h0, 1'b0, 1);
    check(7'h28, 32'h0, 1'b0, 1);
    check(7'h1C, 32'h0, 1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].we, TBL[i].addr, TBL[i].wdata, TBL[i].ev);
      check(TBL[i].chk, TBL[i].exp_rd, TBL[i].exp_irq, int'(TBL[i].req));
    end

    // R4 every bit cleared and re-raised in the same cycle
    step(1'b0, 7'h00, 32'h0, 7'h7F);
    step(1'b1, 7'h20, 32'hFFFFFFFF, 7'h7F);
    check(7'h20, 32'h7F, 1'b0, 4);
    // R3 clear all
    step(1'b1, 7'h20, 32'h7F, 7'h00);
    check(7'h20, 32'h0, 1'b0, 3);
    // R8 soft reset wins over simultaneous event
    step(1'b1, 7'h28, 32'h7F, 7'h00);
    step(1'b1, 7'h1C, 32'h80000000, 7'h00);
    step(1'b1, 7'h40, 32'hFFFFFFFA, 7'h41);
    check(7'h20, 32'h0, 1'b0, 8);
    // R7 every source raises irq when both stages open
    step(1'b1, 7'h28, 32'h7F, 7'h00);
    step(1'b1, 7'h1C, 32'h80000000, 7'h00);
    for (int b = 0; b < 7; b++) begin
      step(1'b0, 7'h00, 32'h0, 7'(1 << b));
      check(7'h20, 32'(1 << b), 1'b1, 7);
      step(1'b1, 7'h20, 32'(1 << b), 7'h00);
      check(7'h20, 32'h0, 1'b0, 7);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule